// File: doc/BRIEF.md
# Receive Bit Stream Output Framer

This block sits between a spread-spectrum demodulator and an external MAC. It passes demodulated header and payload bits to the MAC over three wires: a serial data line, a gated bit clock and an active-high data-ready envelope. The demodulator tells the framer when a frame delimiter has been found, when the header is bad, when the 16-bit header check field is passing, and when each new bit is valid. The framer uses these to open and close the envelope and to start and stop the clock.

Bits go out in the order the demodulator strobes them. The demodulator already delivers each byte least significant bit first, so that order is kept. The bit clock is produced inside the block from the system clock. Its half period comes from a two-bit rate code. The data line changes on the falling edge of the non-inverted clock, so the MAC can sample it on the rising edge. A static configuration input inverts the clock polarity. While receive-enable is low, or after the envelope has closed, the clock and data lines stay low.

Top module: `rx_out_framer`

## Requirements
- R1: While reset is high, and on the first cycle after it, rx_env, rx_bclk and rx_data are all 0.
- R2: When sfd_det is sampled high with rx_en high and hdr_err low, rx_env is 1 from the next cycle on.
- R3: When rx_en is sampled low or hdr_err is sampled high, rx_env is 0 on the next cycle. This wins over a sfd_det or bit_stb in the same cycle, and a sfd_det while rx_en is low does not open the envelope.
- R4: On the cycle after rx_en is sampled low or hdr_err is sampled high, rx_bclk and rx_data are 0, and they stay 0 for as long as rx_env is 0.
- R5: A bit_stb sampled while the envelope is open loads bit_in onto rx_data on the next cycle and drives the non-inverted clock low at that same edge. The clock goes high again a half period later, and rx_data holds its value until the next accepted strobe.
- R6: The half period, in system clock cycles, is CLK_KHZ / (2 x rate). The rate is chosen by rate_sel: 0 = 1000, 1 = 2000, 2 = 5500, 3 = 11000 kbit/s. With the default 44000 kHz this gives 22, 11, 4 and 2 cycles. The rate is sampled with each strobe.
- R7: On the cycle after crc_field is sampled high, rx_bclk is 0 whatever clk_inv is.
- R8: With clk_inv high, rx_bclk is the inverse of the non-inverted clock whenever the envelope is open and crc_field was low on the previous cycle.
- R9: A bit_stb sampled while the envelope is closed, including in the same cycle as the sfd_det that opens it, is ignored: rx_data and rx_bclk do not change.
- R10: After sfd_det opens the envelope, rx_data is 0 and the non-inverted clock is high, so the first accepted strobe produces a falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_en | input | 1 | Receive enable; low puts the framer in standby |
| sfd_det | input | 1 | One-cycle pulse: frame delimiter found |
| hdr_err | input | 1 | One-cycle pulse: header error detected |
| crc_field | input | 1 | High while the 16-bit header check field is received |
| bit_stb | input | 1 | One-cycle pulse: bit_in is a new demodulated bit |
| bit_in | input | 1 | Demodulated bit |
| rate_sel | input | 2 | Bit rate code, sampled with bit_stb |
| clk_inv | input | 1 | Invert the toggling output clock |
| rx_env | output | 1 | Data-ready envelope |
| rx_bclk | output | 1 | Gated output bit clock |
| rx_data | output | 1 | Serial output data |

## Verification
Two pairs of events can land in the same cycle. A header error can arrive together with a bit strobe, and receive-enable can drop together with a frame delimiter. The random frames put hdr_err on the same cycle as a chosen strobe, and the directed cases sample sfd_det while rx_en is low. In both cases the shutdown must win: the envelope, clock and data must all read 0 on the next cycle, and the strobed bit must never appear. A bench model that is updated from the requirements judges every cycle. The per-cycle compare is tagged with the requirement whose output differs.

// File: rtl/rx_out_framer_pkg.sv
package rx_out_framer_pkg;

    typedef enum logic [1:0] {
        RATE_1M   = 2'd0,
        RATE_2M   = 2'd1,
        RATE_5M5  = 2'd2,
        RATE_11M  = 2'd3
    } rate_e;

    // Bit rate in kbit/s for each rate code.
    function automatic int rate_kbps(input rate_e code);
        case (code)
            RATE_1M:  return 1000;
            RATE_2M:  return 2000;
            RATE_5M5: return 5500;
            default:  return 11000;
        endcase
    endfunction

    // Half bit period in system clock cycles.
    function automatic int half_cycles(input int clk_khz, input rate_e code);
        return clk_khz / (2 * rate_kbps(code));
    endfunction

    // Frame control events shared by the sub-blocks.
    typedef struct packed {
        logic kill;   // standby or header error: close everything
        logic start;  // delimiter accepted: open envelope
    } frm_ev_t;

endpackage

// File: rtl/rx_env_ctl.sv
module rx_env_ctl
    import rx_out_framer_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    rx_en,
    input  logic    sfd_det,
    input  logic    hdr_err,
    output frm_ev_t ev,
    output logic    env_q
);
    always_comb begin
        ev.kill  = !rx_en || hdr_err;
        ev.start = sfd_det && !ev.kill && !env_q;
    end

    always_ff @(posedge clk) begin
        if (rst || ev.kill) begin
            env_q <= 1'b0;
        end else if (ev.start) begin
            env_q <= 1'b1;
        end
    end
endmodule

// File: rtl/rx_bit_timer.sv
module rx_bit_timer
    import rx_out_framer_pkg::*;
#(
    parameter int CLK_KHZ = 44000,
    parameter int CNT_W   = 5
) (
    input  logic        clk,
    input  logic        rst,
    input  frm_ev_t     ev,
    input  logic        env_q,
    input  logic        bit_stb,
    input  logic [1:0]  rate_sel,
    output logic        accept,
    output logic        phase_q
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] reload;

    always_comb begin
        accept = env_q && !ev.kill && bit_stb;
        reload = CNT_W'(half_cycles(CLK_KHZ, rate_e'(rate_sel)) - 1);
    end

    always_ff @(posedge clk) begin
        if (rst || ev.kill) begin
            phase_q <= 1'b0;
            cnt_q   <= '0;
        end else if (ev.start) begin
            phase_q <= 1'b1;
            cnt_q   <= '0;
        end else if (accept) begin
            phase_q <= 1'b0;
            cnt_q   <= reload;
        end else if (env_q && !phase_q) begin
            if (cnt_q == '0) begin
                phase_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/rx_ser_out.sv
module rx_ser_out
    import rx_out_framer_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  frm_ev_t ev,
    input  logic    accept,
    input  logic    bit_in,
    input  logic    env_q,
    input  logic    phase_q,
    input  logic    crc_field,
    input  logic    clk_inv,
    output logic    rx_bclk,
    output logic    rx_data
);
    logic data_q;
    logic crc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= 1'b0;
            crc_q  <= 1'b0;
        end else begin
            crc_q <= crc_field;
            if (ev.kill || ev.start) begin
                data_q <= 1'b0;
            end else if (accept) begin
                data_q <= bit_in;
            end
        end
    end

    always_comb begin
        rx_bclk = env_q && !crc_q && (phase_q ^ clk_inv);
        rx_data = env_q && data_q;
    end
endmodule

// File: rtl/rx_out_framer.sv
module rx_out_framer
    import rx_out_framer_pkg::*;
#(
    parameter int CLK_KHZ = 44000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_en,
    input  logic       sfd_det,
    input  logic       hdr_err,
    input  logic       crc_field,
    input  logic       bit_stb,
    input  logic       bit_in,
    input  logic [1:0] rate_sel,
    input  logic       clk_inv,
    output logic       rx_env,
    output logic       rx_bclk,
    output logic       rx_data
);
    localparam int MAX_HALF = half_cycles(CLK_KHZ, RATE_1M);
    localparam int CNT_W    = (MAX_HALF < 2) ? 1 : $clog2(MAX_HALF);

    frm_ev_t ev;
    logic    env_q;
    logic    accept;
    logic    phase_q;

    rx_env_ctl u_env (
        .clk     (clk),
        .rst     (rst),
        .rx_en   (rx_en),
        .sfd_det (sfd_det),
        .hdr_err (hdr_err),
        .ev      (ev),
        .env_q   (env_q)
    );

    rx_bit_timer #(
        .CLK_KHZ (CLK_KHZ),
        .CNT_W   (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .env_q    (env_q),
        .bit_stb  (bit_stb),
        .rate_sel (rate_sel),
        .accept   (accept),
        .phase_q  (phase_q)
    );

    rx_ser_out u_ser (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .accept    (accept),
        .bit_in    (bit_in),
        .env_q     (env_q),
        .phase_q   (phase_q),
        .crc_field (crc_field),
        .clk_inv   (clk_inv),
        .rx_bclk   (rx_bclk),
        .rx_data   (rx_data)
    );

    assign rx_env = env_q;
endmodule

// File: rtl/rx_out_framer_chk.sv
module rx_out_framer_chk (
    input logic clk,
    input logic rst,
    input logic rx_en,
    input logic sfd_det,
    input logic hdr_err,
    input logic crc_field,
    input logic bit_stb,
    input logic clk_inv,
    input logic rx_env,
    input logic rx_bclk,
    input logic rx_data
);
    p_env_open_r2: assert property (@(posedge clk) disable iff (rst)
        (rx_en && sfd_det && !hdr_err) |=> rx_env);

    p_env_close_r3: assert property (@(posedge clk) disable iff (rst)
        (!rx_en || hdr_err) |=> !rx_env);

    p_quiet_after_close_r4: assert property (@(posedge clk) disable iff (rst)
        (!rx_en || hdr_err) |=> (!rx_bclk && !rx_data));

    p_crc_clock_low_r7: assert property (@(posedge clk) disable iff (rst)
        crc_field |=> !rx_bclk);

    p_data_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (rx_env && rx_en && !hdr_err && !bit_stb) |=> $stable(rx_data));

    p_strobe_fall_r5: assert property (@(posedge clk) disable iff (rst)
        (rx_env && rx_en && !hdr_err && bit_stb && !crc_field && !clk_inv) |=> !rx_bclk);

    p_closed_strobe_r9: assert property (@(posedge clk) disable iff (rst)
        (!rx_env && bit_stb && !sfd_det) |=> (!rx_data && !rx_bclk));
endmodule

bind rx_out_framer rx_out_framer_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .rx_en     (rx_en),
    .sfd_det   (sfd_det),
    .hdr_err   (hdr_err),
    .crc_field (crc_field),
    .bit_stb   (bit_stb),
    .clk_inv   (clk_inv),
    .rx_env    (rx_env),
    .rx_bclk   (rx_bclk),
    .rx_data   (rx_data)
);

// File: tb/test_rx_out_framer.sv
module test_rx_out_framer;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_en = 1'b0, sfd_det = 1'b0, hdr_err = 1'b0, crc_field = 1'b0;
    logic       bit_stb = 1'b0, bit_in = 1'b0, clk_inv = 1'b0;
    logic [1:0] rate_sel = 2'd0;
    logic       rx_env, rx_bclk, rx_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    rx_out_framer i_rx_out_framer (
        .clk(clk), .rst(rst), .rx_en(rx_en), .sfd_det(sfd_det), .hdr_err(hdr_err),
        .crc_field(crc_field), .bit_stb(bit_stb), .bit_in(bit_in), .rate_sel(rate_sel),
        .clk_inv(clk_inv), .rx_env(rx_env), .rx_bclk(rx_bclk), .rx_data(rx_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // R6: half period in cycles at 44000 kHz for each rate code.
    function automatic int exp_half(input logic [1:0] code);
        int kbps;
        case (code)
            2'd0: kbps = 1000;
            2'd1: kbps = 2000;
            2'd2: kbps = 5500;
            default: kbps = 11000;
        endcase
        return 44000 / (2 * kbps);
    endfunction

    // Reference model built from the requirements.
    logic m_env = 1'b0, m_phase = 1'b0, m_data = 1'b0, m_crc = 1'b0;
    int   m_cnt = 0;

    always @(posedge clk) begin
        m_crc <= rst ? 1'b0 : crc_field;
        if (rst || !rx_en || hdr_err) begin
            m_env <= 1'b0; m_phase <= 1'b0; m_data <= 1'b0; m_cnt <= 0;
        end else if (sfd_det && !m_env) begin
            m_env <= 1'b1; m_phase <= 1'b1; m_data <= 1'b0; m_cnt <= 0;
        end else if (m_env && bit_stb) begin
            m_data <= bit_in; m_phase <= 1'b0; m_cnt <= exp_half(rate_sel) - 1;
        end else if (m_env && !m_phase) begin
            if (m_cnt == 0) m_phase <= 1'b1;
            else m_cnt <= m_cnt - 1;
        end
    end

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_int(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison, away from both clock edges.
    always @(negedge clk) begin
        #(CLK_PERIOD/4);
        if (!done) begin
            logic e_bclk;
            e_bclk = m_env && !m_crc && (m_phase ^ clk_inv);
            check(m_env ? "R2 envelope" : "R3 envelope", rx_env, m_env);
            if (m_crc)        check("R7 clock in check field", rx_bclk, e_bclk);
            else if (!m_env)  check("R4 idle clock", rx_bclk, e_bclk);
            else if (clk_inv) check("R8 inverted clock", rx_bclk, e_bclk);
            else              check("R5 R6 clock timing", rx_bclk, e_bclk);
            check(m_env ? "R5 data" : "R4 idle data", rx_data, m_env && m_data);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frame(input logic [1:0] rate, input int nbits, input int crc_lo,
                         input int err_bit, input int drop_bit, input int sfd_bit,
                         input logic inv);
        rate_sel = rate; clk_inv = inv; rx_en = 1'b1;
        sfd_det = 1'b1; cyc(1); sfd_det = 1'b0;
        cyc(2);
        for (int i = 0; i < nbits; i++) begin
            bit_in    = 1'($urandom);
            bit_stb   = 1'b1;
            crc_field = (i >= crc_lo) && (i < crc_lo + 16);
            hdr_err   = (i == err_bit);
            sfd_det   = (i == sfd_bit);
            rx_en     = (i != drop_bit);
            cyc(1);
            bit_stb = 1'b0; hdr_err = 1'b0; sfd_det = 1'b0; rx_en = 1'b1;
            cyc(2 * exp_half(rate) - 1);
        end
        crc_field = 1'b0;
        rx_en = 1'b0; cyc(1); rx_en = 1'b1; cyc(2);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        cyc(3);
        // R1: reset holds all outputs low.
        check("R1 reset env", rx_env, 1'b0);
        check("R1 reset bclk", rx_bclk, 1'b0);
        check("R1 reset data", rx_data, 1'b0);
        rst = 1'b0;
        cyc(1);
        check("R1 after reset env", rx_env, 1'b0);

        // R9: strobes with no open envelope are ignored.
        rx_en = 1'b1;
        for (int i = 0; i < 3; i++) begin
            bit_in = 1'b1; bit_stb = 1'b1; cyc(1); bit_stb = 1'b0;
            check("R9 ignored strobe data", rx_data, 1'b0);
            check("R9 ignored strobe clock", rx_bclk, 1'b0);
        end

        // R3: delimiter while receive-enable low.
        rx_en = 1'b0; sfd_det = 1'b1; cyc(1); sfd_det = 1'b0; rx_en = 1'b1;
        check("R3 sfd in standby", rx_env, 1'b0);

        // R9: strobe together with the opening delimiter is ignored; R10 start state.
        sfd_det = 1'b1; bit_stb = 1'b1; bit_in = 1'b1; cyc(1);
        sfd_det = 1'b0; bit_stb = 1'b0;
        check("R2 open", rx_env, 1'b1);
        check("R9 strobe with sfd", rx_data, 1'b0);
        check("R10 clock high after open", rx_bclk, 1'b1);
        rx_en = 1'b0; cyc(1); rx_en = 1'b1; cyc(1);

        // R6: measure the low half period for every rate code.
        for (int r = 0; r < 4; r++) begin
            int n;
            rate_sel = 2'(r); clk_inv = 1'b0;
            sfd_det = 1'b1; cyc(1); sfd_det = 1'b0; cyc(1);
            bit_in = 1'b1; bit_stb = 1'b1; cyc(1); bit_stb = 1'b0;
            n = 0;
            while (rx_bclk == 1'b0 && n < 100) begin n++; cyc(1); end
            check_int("R6 half period", n, exp_half(2'(r)));
            rx_en = 1'b0; cyc(1); rx_en = 1'b1; cyc(1);
        end

        // R3 R4: header error on the same cycle as a strobe.
        rate_sel = 2'd3;
        sfd_det = 1'b1; cyc(1); sfd_det = 1'b0; cyc(1);
        bit_in = 1'b1; bit_stb = 1'b1; hdr_err = 1'b1; cyc(1);
        bit_stb = 1'b0; hdr_err = 1'b0;
        check("R3 close on header error", rx_env, 1'b0);
        check("R4 data low on header error", rx_data, 1'b0);
        check("R4 clock low on header error", rx_bclk, 1'b0);
        cyc(2);

        // Random frames with collisions and gating windows.
        for (int f = 0; f < 24; f++) begin
            int nb, cl, eb, db, sb;
            nb = 20 + int'($urandom_range(20));
            cl = int'($urandom_range(nb));
            eb = ($urandom_range(3) == 0) ? int'($urandom_range(nb - 1)) : -1;
            db = ($urandom_range(4) == 0) ? int'($urandom_range(nb - 1)) : -1;
            sb = ($urandom_range(3) == 0) ? int'($urandom_range(nb - 1)) : -1;
            frame(2'($urandom_range(3)), nb, cl, eb, db, sb, 1'($urandom));
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule